// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block collects eight interrupt request lines and decides whether to raise a single interrupt output towards a processor. Each line has its own trigger mode. A level-triggered line requests while its input is high. An edge-triggered line latches a request on a low-to-high transition. Requests pass through a mask. The surviving requests are ranked in a circular order whose starting point, the rotation offset, can be moved. The best of them is compared with the best line currently in service.

The processor answers the output with an acknowledge pulse. The block then returns the granted line number and an 8-bit vector, and marks the line as in service. The block can optionally end service automatically at acknowledge time, and can move the rotation offset when it does. End-of-service and rotation commands come in on a strobe with a 3-bit opcode and a line field. When the nested option is on in the master role, the cascade line (line 2) is left out of the in-service comparison.

Top module: `prio_irq_resolver`

## Requirements
- R1: While reset is held, `int_req` and `ack_valid` are 0. Reset clears the request, in-service, mask, previous-level and rotation-offset state, so the rotation offset is 0 after reset.
- R2: A line whose `trig_level` bit is 1 requests exactly while its input is high. `int_req` falls again once the input drops.
- R3: A line whose `trig_level` bit is 0 latches a request on a low-to-high input transition. The request stays latched after the input returns low. A new request needs a new rising transition.
- R4: A request whose mask bit is 1 cannot raise `int_req`. Writing the mask with `mask_we` takes effect on the next edge.
- R5: Ranking starts at the line equal to the rotation offset and proceeds upward, wrapping from line 7 to line 0. The offset line has the highest rank.
- R6: `int_req` is 1 only when the best unmasked request ranks strictly higher than the best in-service line. An empty set ranks below every line, and an equal rank does not raise the output.
- R7: When `nested_en` and `is_master` are both 1, in-service line 2 is left out of the comparison of R6.
- R8: An acknowledge sets the in-service bit of the granted line. It clears that line's request only if the line is edge-triggered, so a level line that is still high requests again once its service ends.
- R9: With `auto_eoi_en` set, an acknowledge leaves the in-service state unchanged. If `auto_eoi_rot` is also set, the rotation offset becomes (granted line + 1) mod 8.
- R10: After an acknowledge, `ack_vector` is `{vec_base, ack_line}`. If no line would win at acknowledge time, `ack_line` is 7, no state changes, and `int_req` stays low.
- R11: Opcode 1 clears the highest-ranked in-service bit, with no exclusion for line 2. Opcode 2 does the same and also sets the offset to (that line + 1) mod 8.
- R12: Opcode 3 clears the in-service bit of `cmd_line`. Opcode 4 sets the offset to (`cmd_line` + 1) mod 8. Opcode 5 does both. Opcodes 0, 6 and 7 have no effect.
- R13: `int_req` is registered and reflects a state change one edge after the edge that made it. `ack_valid`, `ack_line` and `ack_vector` are valid for the one cycle after the edge that samples `inta`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 8 | Interrupt request inputs |
| trig_level | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| mask_we | input | 1 | Load strobe for the mask |
| mask_data | input | 8 | New mask value, 1 = line masked |
| vec_base | input | 5 | Upper bits of the returned vector |
| auto_eoi_en | input | 1 | End service automatically at acknowledge |
| auto_eoi_rot | input | 1 | Rotate the offset on automatic end of service |
| nested_en | input | 1 | Nested option, excludes line 2 from the in-service compare |
| is_master | input | 1 | This instance acts as master |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode, 1 to 5 as in R11 and R12 |
| cmd_line | input | 3 | Line field of the command |
| inta | input | 1 | Acknowledge pulse |
| int_req | output | 1 | Registered interrupt output |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_line | output | 3 | Granted line, 7 when spurious |
| ack_vector | output | 8 | Granted vector |

## Verification
An input transition is captured into the request state at the first rising edge, and `int_req` shows it at the second. A mask write or a command changes state at its own edge and is seen on `int_req` one edge later. Acknowledge results appear right after the edge that samples `inta`. The bench drives every input on the falling edge. It then waits two rising edges before it reads `int_req`, and reads the acknowledge outputs at the falling edge that follows the sampling edge, so each check falls inside the cycle in which its result is due.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int PIR_LINES = 8;
  localparam int PIR_VEC_W = 8;
  localparam int PIR_CASCADE = 2;

  typedef enum logic [2:0] {
    OP_NOP          = 3'd0,
    OP_EOI          = 3'd1,
    OP_EOI_ROT      = 3'd2,
    OP_EOI_SPEC     = 3'd3,
    OP_SET_LOW      = 3'd4,
    OP_EOI_SPEC_ROT = 3'd5
  } pir_op_e;
endpackage

// File: rtl/pir_rst_sync.sv
module pir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pir_prio_find.sv
// Rank of the best set bit of vec, counted from offset upward with wrap.
// Result N means the set is empty. N must be a power of two.
module pir_prio_find #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] offset,
  output logic [LW:0]   prio
);
  logic [N-1:0]  rot;
  logic [LW-1:0] idx;

  always_comb begin
    idx = '0;
    for (int k = 0; k < N; k++) begin
      idx    = LW'(k) + offset;
      rot[k] = vec[idx];
    end
  end

  always_comb begin
    prio = (LW+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) prio = (LW+1)'(k);
    end
  end
endmodule

// File: rtl/pir_req_capture.sv
module pir_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] trig_level,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] irr_d;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = lines;
    for (int i = 0; i < N; i++) begin
      if (trig_level[i]) irr_d[i] = lines[i];
      else               irr_d[i] = (irr_q[i] & ~ack_clr[i]) | (lines[i] & ~prev_q[i]);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      irr_q  <= '0;
      prev_q <= '0;
    end else begin
      irr_q  <= irr_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/pir_isr_ctrl.sv
module pir_isr_ctrl
  import pir_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [N-1:0]  trig_level,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_data,
  input  logic          auto_eoi_en,
  input  logic          auto_eoi_rot,
  input  logic          inta,
  input  logic          grant_found,
  input  logic [LW-1:0] grant_line,
  input  logic          top_found,
  input  logic [LW-1:0] top_line,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [LW-1:0] cmd_line,
  output logic [N-1:0]  isr_q,
  output logic [N-1:0]  mask_q,
  output logic [LW-1:0] offset_q,
  output logic [N-1:0]  ack_clr
);
  logic [N-1:0]  isr_d;
  logic [N-1:0]  mask_d;
  logic [LW-1:0] offset_d;
  logic [N-1:0]  grant_oh;
  logic          upd_en;

  assign grant_oh = N'(1) << grant_line;
  assign upd_en   = mask_we | inta | cmd_valid;

  always_comb begin
    isr_d    = isr_q;
    mask_d   = mask_q;
    offset_d = offset_q;
    ack_clr  = '0;
    if (mask_we) mask_d = mask_data;
    if (inta && grant_found) begin
      isr_d   = isr_d | grant_oh;
      ack_clr = grant_oh & ~trig_level;
      if (auto_eoi_en) begin
        isr_d = isr_d & ~grant_oh;
        if (auto_eoi_rot) offset_d = grant_line + LW'(1);
      end
    end
    if (cmd_valid) begin
      case (cmd_op)
        OP_EOI, OP_EOI_ROT: begin
          if (top_found) begin
            isr_d = isr_d & ~(N'(1) << top_line);
            if (cmd_op == OP_EOI_ROT) offset_d = top_line + LW'(1);
          end
        end
        OP_EOI_SPEC:     isr_d = isr_d & ~(N'(1) << cmd_line);
        OP_SET_LOW:      offset_d = cmd_line + LW'(1);
        OP_EOI_SPEC_ROT: begin
          isr_d    = isr_d & ~(N'(1) << cmd_line);
          offset_d = cmd_line + LW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      isr_q    <= '0;
      mask_q   <= '0;
      offset_q <= '0;
    end else if (upd_en) begin
      isr_q    <= isr_d;
      mask_q   <= mask_d;
      offset_q <= offset_d;
    end
  end
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import pir_pkg::*;
#(
  parameter int N_LINES = PIR_LINES,
  parameter int VEC_W   = PIR_VEC_W,
  parameter int CASCADE = PIR_CASCADE,
  parameter int LW      = $clog2(N_LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  irq_lines,
  input  logic [N_LINES-1:0]  trig_level,
  input  logic                mask_we,
  input  logic [N_LINES-1:0]  mask_data,
  input  logic [VEC_W-LW-1:0] vec_base,
  input  logic                auto_eoi_en,
  input  logic                auto_eoi_rot,
  input  logic                nested_en,
  input  logic                is_master,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [LW-1:0]       cmd_line,
  input  logic                inta,
  output logic                int_req,
  output logic                ack_valid,
  output logic [LW-1:0]       ack_line,
  output logic [VEC_W-1:0]    ack_vector
);
  logic               srst_n;
  logic [N_LINES-1:0] irr_q, isr_q, mask_q, ack_clr;
  logic [N_LINES-1:0] pend_vec, cmp_vec;
  logic [LW-1:0]      offset_q;
  logic [LW:0]        pend_prio, cmp_prio, top_prio;
  logic [LW-1:0]      pend_line, top_line;
  logic               want, top_found;
  logic               int_req_d, ack_valid_d;
  logic [LW-1:0]      ack_line_d;

  pir_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  pir_req_capture #(.N(N_LINES)) u_cap (
    .clk(clk), .srst_n(srst_n), .lines(irq_lines), .trig_level(trig_level),
    .ack_clr(ack_clr), .irr_q(irr_q)
  );

  assign pend_vec = irr_q & ~mask_q;
  assign cmp_vec  = (nested_en && is_master) ? (isr_q & ~(N_LINES'(1) << CASCADE)) : isr_q;

  pir_prio_find #(.N(N_LINES), .LW(LW)) u_pend (.vec(pend_vec), .offset(offset_q), .prio(pend_prio));
  pir_prio_find #(.N(N_LINES), .LW(LW)) u_cmp  (.vec(cmp_vec),  .offset(offset_q), .prio(cmp_prio));
  pir_prio_find #(.N(N_LINES), .LW(LW)) u_top  (.vec(isr_q),    .offset(offset_q), .prio(top_prio));

  assign pend_line = pend_prio[LW-1:0] + offset_q;
  assign top_line  = top_prio[LW-1:0] + offset_q;
  assign top_found = ~top_prio[LW];
  assign want      = ~pend_prio[LW] && (pend_prio < cmp_prio);

  pir_isr_ctrl #(.N(N_LINES), .LW(LW)) u_ctrl (
    .clk(clk), .srst_n(srst_n), .trig_level(trig_level),
    .mask_we(mask_we), .mask_data(mask_data),
    .auto_eoi_en(auto_eoi_en), .auto_eoi_rot(auto_eoi_rot),
    .inta(inta), .grant_found(want), .grant_line(pend_line),
    .top_found(top_found), .top_line(top_line),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
    .isr_q(isr_q), .mask_q(mask_q), .offset_q(offset_q), .ack_clr(ack_clr)
  );

  always_comb begin
    int_req_d   = want;
    ack_valid_d = inta;
    ack_line_d  = want ? pend_line : LW'(N_LINES - 1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      int_req    <= 1'b0;
      ack_valid  <= 1'b0;
      ack_line   <= '0;
      ack_vector <= '0;
    end else begin
      int_req   <= int_req_d;
      ack_valid <= ack_valid_d;
      if (inta) begin
        ack_line   <= ack_line_d;
        ack_vector <= {vec_base, ack_line_d};
      end
    end
  end
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
  parameter int N  = 8,
  parameter int VW = 8,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          srst_n,
  input logic [N-1:0]  irq_lines,
  input logic [N-1:0]  trig_level,
  input logic [VW-LW-1:0] vec_base,
  input logic          auto_eoi_en,
  input logic          inta,
  input logic          cmd_valid,
  input logic          int_req,
  input logic          ack_valid,
  input logic [VW-1:0] ack_vector,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  isr,
  input logic [N-1:0]  mask
);
  for (genvar i = 0; i < N; i++) begin : g_lvl
    // R2
    p_level_follow_r2: assert property (@(posedge clk) disable iff (!srst_n)
      trig_level[i] |=> (irr[i] == $past(irq_lines[i])));
  end

  // R4 and R6
  p_no_pend_low_r6: assert property (@(posedge clk) disable iff (!srst_n)
    ((irr & ~mask) == '0) |=> !int_req);

  p_rise_needs_pend_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(int_req) |-> ($past(irr & ~mask) != '0));

  // R9
  p_aeoi_isr_kept_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (auto_eoi_en && inta && !cmd_valid) |=> (isr == $past(isr)));

  // R13
  p_ack_follows_r13: assert property (@(posedge clk) disable iff (!srst_n)
    inta |=> ack_valid);

  p_ack_idle_r13: assert property (@(posedge clk) disable iff (!srst_n)
    !inta |=> !ack_valid);

  // R10
  p_vec_base_r10: assert property (@(posedge clk) disable iff (!srst_n)
    ack_valid |-> (ack_vector[VW-1:LW] == $past(vec_base)));
endmodule

bind prio_irq_resolver pir_checker #(.N(N_LINES), .VW(VEC_W), .LW(LW)) u_chk (
  .clk(clk), .srst_n(srst_n), .irq_lines(irq_lines), .trig_level(trig_level),
  .vec_base(vec_base), .auto_eoi_en(auto_eoi_en), .inta(inta), .cmd_valid(cmd_valid),
  .int_req(int_req), .ack_valid(ack_valid), .ack_vector(ack_vector),
  .irr(irr_q), .isr(isr_q), .mask(mask_q)
);

// File: tb/prio_irq_resolver_bench.sv
`timescale 1ns/100ps
module prio_irq_resolver_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_lines, trig_level, mask_data;
  logic       mask_we, auto_eoi_en, auto_eoi_rot, nested_en, is_master;
  logic [4:0] vec_base;
  logic       cmd_valid, inta;
  logic [2:0] cmd_op, cmd_line;
  logic       int_req, ack_valid;
  logic [2:0] ack_line;
  logic [7:0] ack_vector;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prio_irq_resolver u_prio_irq_resolver (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .trig_level(trig_level),
    .mask_we(mask_we), .mask_data(mask_data), .vec_base(vec_base),
    .auto_eoi_en(auto_eoi_en), .auto_eoi_rot(auto_eoi_rot),
    .nested_en(nested_en), .is_master(is_master),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line), .inta(inta),
    .int_req(int_req), .ack_valid(ack_valid), .ack_line(ack_line), .ack_vector(ack_vector)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    irq_lines = '0; trig_level = '0; mask_we = 0; mask_data = '0;
    vec_base = 5'b01000; auto_eoi_en = 0; auto_eoi_rot = 0;
    nested_en = 0; is_master = 1; cmd_valid = 0; cmd_op = '0; cmd_line = '0; inta = 0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic ack(input string tag, input int exp_line);
    inta = 1'b1;
    tick(1);
    chk({tag, " ack_valid"}, int'(ack_valid), 1);
    chk({tag, " ack_line"}, int'(ack_line), exp_line);
    chk({tag, " ack_vector"}, int'(ack_vector), {vec_base, 3'(exp_line)});
    inta = 1'b0;
    tick(2);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] ln);
    cmd_valid = 1'b1; cmd_op = op; cmd_line = ln;
    tick(1);
    cmd_valid = 1'b0;
    tick(2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(2);
    chk("R1 int_req in reset", int'(int_req), 0);
    chk("R1 ack_valid in reset", int'(ack_valid), 0);
    do_reset();
    chk("R1 int_req after reset", int'(int_req), 0);
  endtask

  task automatic t_level();
    do_reset();
    trig_level[3] = 1'b1;
    irq_lines[3] = 1'b1;
    tick(1);
    chk("R13 int_req not yet", int'(int_req), 0);
    tick(1);
    chk("R2 level request raises", int'(int_req), 1);
    irq_lines[3] = 1'b0;
    tick(2);
    chk("R2 level request follows low", int'(int_req), 0);
  endtask

  task automatic t_edge();
    do_reset();
    irq_lines[5] = 1'b1;
    tick(2);
    chk("R3 edge request raises", int'(int_req), 1);
    irq_lines[5] = 1'b0;
    tick(2);
    chk("R3 edge request held", int'(int_req), 1);
    ack("R10 edge", 5);
    chk("R8 in-service blocks", int'(int_req), 0);
    cmd(3'd1, 3'd0);
    chk("R8 edge request cleared at ack", int'(int_req), 0);
    irq_lines[5] = 1'b1;
    tick(2);
    chk("R3 new rise requests again", int'(int_req), 1);
  endtask

  task automatic t_mask();
    do_reset();
    mask_we = 1'b1; mask_data = 8'h02;
    tick(1);
    mask_we = 1'b0;
    irq_lines[1] = 1'b1;
    tick(2);
    chk("R4 masked line quiet", int'(int_req), 0);
    mask_we = 1'b1; mask_data = 8'h00;
    tick(1);
    mask_we = 1'b0;
    tick(1);
    chk("R4 unmask raises", int'(int_req), 1);
    ack("R4 unmasked", 1);
  endtask

  task automatic t_prio();
    do_reset();
    irq_lines = 8'h44;
    tick(2);
    ack("R5 offset zero", 2);
    do_reset();
    cmd(3'd4, 3'd3);
    irq_lines = 8'h44;
    tick(2);
    ack("R12 set-lowest offset four", 6);
  endtask

  task automatic t_nest();
    do_reset();
    trig_level[4] = 1'b1;
    irq_lines[4] = 1'b1;
    tick(2);
    ack("R6 first", 4);
    chk("R6 equal rank no request", int'(int_req), 0);
    irq_lines[6] = 1'b1;
    tick(2);
    chk("R6 lower rank no request", int'(int_req), 0);
    irq_lines[1] = 1'b1;
    tick(2);
    chk("R6 higher rank requests", int'(int_req), 1);
    ack("R6 nested", 1);
    cmd(3'd1, 3'd0);
    cmd(3'd1, 3'd0);
    ack("R8 level request retained", 4);
  endtask

  task automatic t_cascade();
    do_reset();
    nested_en = 1'b1;
    irq_lines[2] = 1'b1;
    tick(2);
    ack("R7 cascade", 2);
    irq_lines[5] = 1'b1;
    tick(2);
    chk("R7 line 2 excluded", int'(int_req), 1);
    is_master = 1'b0;
    tick(2);
    chk("R7 not master", int'(int_req), 0);
    is_master = 1'b1; nested_en = 1'b0;
    tick(2);
    chk("R7 option off", int'(int_req), 0);
  endtask

  task automatic t_aeoi();
    do_reset();
    auto_eoi_en = 1'b1;
    irq_lines[1] = 1'b1;
    tick(2);
    ack("R9 auto first", 1);
    irq_lines[6] = 1'b1;
    tick(2);
    chk("R9 in-service cleared", int'(int_req), 1);
    ack("R9 auto second", 6);
    auto_eoi_rot = 1'b1;
    irq_lines[3] = 1'b1;
    tick(2);
    ack("R9 rotate", 3);
    irq_lines[2] = 1'b1; irq_lines[5] = 1'b1;
    tick(2);
    ack("R9 offset moved", 5);
  endtask

  task automatic t_spurious();
    do_reset();
    vec_base = 5'b01001;
    ack("R10 spurious", 7);
    chk("R10 spurious no request", int'(int_req), 0);
  endtask

  task automatic t_eoi();
    do_reset();
    irq_lines[2] = 1'b1;
    tick(2);
    ack("R11 first", 2);
    irq_lines[0] = 1'b1;
    tick(2);
    ack("R11 nested", 0);
    irq_lines[5] = 1'b1;
    tick(2);
    chk("R11 blocked", int'(int_req), 0);
    cmd(3'd1, 3'd0);
    chk("R11 only top cleared", int'(int_req), 0);
    cmd(3'd2, 3'd0);
    chk("R11 rotate eoi clears", int'(int_req), 1);
    irq_lines[1] = 1'b1;
    tick(2);
    ack("R11 offset three", 5);
    cmd(3'd6, 3'd0);
    cmd(3'd7, 3'd0);
    chk("R12 reserved opcodes", int'(int_req), 0);
  endtask

  task automatic t_spec();
    do_reset();
    irq_lines[3] = 1'b1;
    tick(2);
    ack("R12 first", 3);
    irq_lines[1] = 1'b1;
    tick(2);
    ack("R12 second", 1);
    cmd(3'd3, 3'd3);
    irq_lines[2] = 1'b1;
    tick(2);
    chk("R12 specific eoi keeps line 1", int'(int_req), 0);
    cmd(3'd5, 3'd1);
    chk("R12 specific rotate clears", int'(int_req), 1);
    irq_lines[0] = 1'b1;
    tick(2);
    ack("R12 offset two", 2);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_mask();
    t_prio();
    t_nest();
    t_cascade();
    t_aeoi();
    t_spurious();
    t_eoi();
    t_spec();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule